// File: doc/BRIEF.md
# Parallel Road Pattern Matcher

This block keeps a bank of stored track patterns and tests all of them at once against coarse hit addresses as they stream in. Every pattern holds one 12-bit superstrip word for each of six layers and a private comparator for each layer. Five layers come from silicon sensors. The sixth carries a coarse track word from a separate tracking chamber. Each layer has its own input bus with a valid bit. When the word on a layer bus equals a pattern's word for that layer, the pattern records a per-layer hit flag. Matching runs while the hits arrive, so no buffering of the event is needed.

When the end-of-event strobe arrives, the block latches a majority threshold. Every pattern whose count of flagged layers reaches that threshold is a road. The road indices are sent out one per handshake in ascending order, followed by an end marker. Accepting the marker clears all flags, and the block is then ready for the next event. Patterns are written one word at a time, and only between events.

Top module: `road_matcher`

## Requirements
- R1: After reset every pattern word is zero, every layer flag is clear, the threshold is six and `road_vld` is low.
- R2: A write on the load port stores `ld_word` in layer `ld_layer` of pattern `ld_pat` only when the block is idle (no event open, no readout running) and neither a hit valid nor `eoe` is high in that cycle. Any other write is dropped, and so is a write to a layer index of six or more.
- R3: A valid hit on layer L sets flag L of every pattern whose layer-L word equals the hit word. All six layers are compared in the same cycle, and hits in the same cycle as `eoe` still count.
- R4: A flag, once set, stays set for the rest of the event when the same word repeats. A word presented on one layer never sets the flag of a different layer.
- R5: On `eoe`, the threshold is taken from `cfg_thr`, with 0 read as 1 and 7 read as 6. A pattern is a road when its number of set flags is at least that threshold.
- R6: During readout, `road_vld` is high and `road_id` gives the lowest road index not yet accepted. While `road_rdy` is low, `road_id` and `road_eoe` hold their values. Each accepted road is reported only once.
- R7: When no roads remain, the block presents `road_vld` with `road_eoe` high and `road_id` zero. Accepting this marker clears every flag and returns the block to idle.
- R8: Hits and `eoe` that arrive during readout are ignored. They change neither the flags nor the threshold.
- R9: An event that matches nothing produces only the end marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_vld | input | 6 | One valid bit per layer bus |
| hit_word | input | 72 | Six 12-bit superstrip words; layer L uses bits [12L+11:12L] |
| eoe | input | 1 | End-of-event strobe |
| cfg_thr | input | 3 | Majority threshold, sampled with `eoe` |
| ld_en | input | 1 | Pattern word write strobe |
| ld_pat | input | 7 | Pattern index to write |
| ld_layer | input | 3 | Layer index to write |
| ld_word | input | 12 | Word to store |
| road_rdy | input | 1 | Downstream accepts the current road |
| road_vld | output | 1 | Road or end marker presented |
| road_id | output | 7 | Pattern index of the road (zero for the marker) |
| road_eoe | output | 1 | Marks the end-of-event item |

## Verification
The bench drives a word that belongs to one pattern's layer 3 onto layer 2. A design that compared across layers would then report a false road. It repeats hits on a layer that is already flagged, and a design that toggled flags would lose the road. It applies thresholds 0 and 7 to check the clamp, since a design without it would report every pattern or none. During readout it holds `road_rdy` low and also sends hits, a second `eoe` and load writes. A design that let any of these through would skip or repeat indices, grow the road list, or corrupt a pattern, and a later event would show that corruption as a wrong or missing road.

// File: rtl/road_pkg.sv
package road_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACCUM = 2'd1,
    ST_READ  = 2'd2
  } rm_state_t;

  // Limit a raw threshold to the range 1..nlayer.
  function automatic int unsigned clamp_thr(input int unsigned raw,
                                            input int unsigned nlayer);
    if (raw == 0)      return 1;
    if (raw > nlayer)  return nlayer;
    return raw;
  endfunction

endpackage

// File: rtl/rm_pattern_bank.sv
module rm_pattern_bank #(
  parameter int NPAT   = 128,
  parameter int NLAYER = 6,
  parameter int WORD_W = 12,
  localparam int PAT_W = $clog2(NPAT),
  localparam int LAY_W = $clog2(NLAYER)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_take,
  input  logic [PAT_W-1:0]         ld_pat,
  input  logic [LAY_W-1:0]         ld_layer,
  input  logic [WORD_W-1:0]        ld_word,
  input  logic [NLAYER-1:0]        hit_vld,
  input  logic [NLAYER*WORD_W-1:0] hit_word,
  input  logic                     match_en,
  input  logic                     flag_clr,
  output logic [NPAT*NLAYER-1:0]   flag_vec
);

  for (genvar p = 0; p < NPAT; p++) begin : g_pat
    for (genvar l = 0; l < NLAYER; l++) begin : g_lay
      logic [WORD_W-1:0] word_q;
      logic              flag_q;
      logic              wr_sel;
      logic              hit_eq;

      assign wr_sel = ld_take && (ld_pat == PAT_W'(p)) && (ld_layer == LAY_W'(l));
      assign hit_eq = hit_vld[l] && (hit_word[l*WORD_W +: WORD_W] == word_q);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      word_q <= '0;
        else if (wr_sel) word_q <= ld_word;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  flag_q <= 1'b0;
        else if (flag_clr)           flag_q <= 1'b0;
        else if (match_en && hit_eq) flag_q <= 1'b1;
      end

      assign flag_vec[p*NLAYER + l] = flag_q;
    end
  end

endmodule

// File: rtl/rm_majority.sv
module rm_majority #(
  parameter int NPAT   = 128,
  parameter int NLAYER = 6,
  localparam int THR_W = $clog2(NLAYER + 1)
) (
  input  logic [NPAT*NLAYER-1:0] flag_vec,
  input  logic [THR_W-1:0]       thr,
  output logic [NPAT-1:0]        road_mask
);

  function automatic logic [THR_W-1:0] ones(input logic [NLAYER-1:0] v);
    logic [THR_W-1:0] c;
    c = '0;
    for (int i = 0; i < NLAYER; i++) c = c + THR_W'(v[i]);
    return c;
  endfunction

  for (genvar p = 0; p < NPAT; p++) begin : g_cnt
    assign road_mask[p] = ones(flag_vec[p*NLAYER +: NLAYER]) >= thr;
  end

endmodule

// File: rtl/rm_road_scan.sv
module rm_road_scan #(
  parameter int NPAT   = 128,
  localparam int PAT_W = $clog2(NPAT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_phase,
  input  logic [NPAT-1:0]  road_mask,
  input  logic             road_rdy,
  output logic             road_vld,
  output logic [PAT_W-1:0] road_id,
  output logic             road_eoe,
  output logic             scan_done
);

  logic [NPAT-1:0]  served_q;
  logic [NPAT-1:0]  pending;
  logic             found;
  logic [PAT_W-1:0] first_idx;

  assign pending = road_mask & ~served_q;

  // Lowest pending index wins.
  always_comb begin
    found     = 1'b0;
    first_idx = '0;
    for (int i = NPAT - 1; i >= 0; i--) begin
      if (pending[i]) begin
        found     = 1'b1;
        first_idx = PAT_W'(i);
      end
    end
  end

  assign road_vld  = rd_phase;
  assign road_eoe  = rd_phase && !found;
  assign road_id   = (rd_phase && found) ? first_idx : '0;
  assign scan_done = rd_phase && road_rdy && !found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          served_q <= '0;
    else if (!rd_phase)                  served_q <= '0;
    else if (road_rdy && found)          served_q[first_idx] <= 1'b1;
  end

endmodule

// File: rtl/road_matcher.sv
module road_matcher
  import road_pkg::*;
#(
  parameter int NPAT   = 128,
  parameter int NLAYER = 6,
  parameter int WORD_W = 12,
  localparam int PAT_W = $clog2(NPAT),
  localparam int LAY_W = $clog2(NLAYER),
  localparam int THR_W = $clog2(NLAYER + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NLAYER-1:0]        hit_vld,
  input  logic [NLAYER*WORD_W-1:0] hit_word,
  input  logic                     eoe,
  input  logic [THR_W-1:0]         cfg_thr,
  input  logic                     ld_en,
  input  logic [PAT_W-1:0]         ld_pat,
  input  logic [LAY_W-1:0]         ld_layer,
  input  logic [WORD_W-1:0]        ld_word,
  input  logic                     road_rdy,
  output logic                     road_vld,
  output logic [PAT_W-1:0]         road_id,
  output logic                     road_eoe
);

  rm_state_t             st_q, st_d;
  logic [THR_W-1:0]      thr_q;
  logic                  hit_any;
  logic                  ld_take;
  logic                  match_en;
  logic                  rd_phase;
  logic                  scan_done;
  logic                  evt_close;
  logic [NPAT*NLAYER-1:0] flag_vec;
  logic [NPAT-1:0]       road_mask;

  assign hit_any   = |hit_vld;
  assign rd_phase  = (st_q == ST_READ);
  assign match_en  = !rd_phase;
  assign evt_close = eoe && !rd_phase;
  assign ld_take   = ld_en && (st_q == ST_IDLE) && !hit_any && !eoe;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (eoe) st_d = ST_READ; else if (hit_any) st_d = ST_ACCUM;
      ST_ACCUM: if (eoe) st_d = ST_READ;
      ST_READ:  if (scan_done) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         thr_q <= THR_W'(NLAYER);
    else if (evt_close) thr_q <= THR_W'(clamp_thr(int'(cfg_thr), NLAYER));
  end

  rm_pattern_bank #(.NPAT(NPAT), .NLAYER(NLAYER), .WORD_W(WORD_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_take  (ld_take),
    .ld_pat   (ld_pat),
    .ld_layer (ld_layer),
    .ld_word  (ld_word),
    .hit_vld  (hit_vld),
    .hit_word (hit_word),
    .match_en (match_en),
    .flag_clr (scan_done),
    .flag_vec (flag_vec)
  );

  rm_majority #(.NPAT(NPAT), .NLAYER(NLAYER)) u_maj (
    .flag_vec  (flag_vec),
    .thr       (thr_q),
    .road_mask (road_mask)
  );

  rm_road_scan #(.NPAT(NPAT)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_phase  (rd_phase),
    .road_mask (road_mask),
    .road_rdy  (road_rdy),
    .road_vld  (road_vld),
    .road_id   (road_id),
    .road_eoe  (road_eoe),
    .scan_done (scan_done)
  );

endmodule

// File: rtl/road_matcher_chk.sv
module road_matcher_chk #(
  parameter int NPAT   = 128,
  parameter int NLAYER = 6,
  localparam int PAT_W = $clog2(NPAT)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   road_vld,
  input logic                   road_rdy,
  input logic [PAT_W-1:0]       road_id,
  input logic                   road_eoe,
  input logic                   ld_take,
  input logic                   rd_phase,
  input logic [NPAT*NLAYER-1:0] flag_vec
);

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (road_vld && !road_rdy) |=> (road_vld && $stable(road_id) && $stable(road_eoe))); // R6

  AST_IDS_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (road_vld && road_rdy && !road_eoe) |=> (!road_vld || road_eoe || road_id > $past(road_id))); // R6

  AST_MARKER_ZERO_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (road_vld && road_eoe) |-> (road_id == '0)); // R7

  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (road_vld && road_rdy && road_eoe) |=> (flag_vec == '0)); // R7

  AST_READOUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_phase && !(road_rdy && road_eoe)) |=> $stable(flag_vec)); // R8

  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_take |-> !road_vld); // R2

endmodule

bind road_matcher road_matcher_chk #(.NPAT(NPAT), .NLAYER(NLAYER)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .road_vld (road_vld),
  .road_rdy (road_rdy),
  .road_id  (road_id),
  .road_eoe (road_eoe),
  .ld_take  (ld_take),
  .rd_phase (rd_phase),
  .flag_vec (flag_vec)
);

// File: tb/tb_road_matcher.sv
module tb_road_matcher;

  localparam int NP = 128;
  localparam int NL = 6;
  localparam int WW = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NL-1:0]    hit_vld = '0;
  logic [NL*WW-1:0] hit_word = '0;
  logic             eoe = 1'b0;
  logic [2:0]       cfg_thr = 3'd6;
  logic             ld_en = 1'b0;
  logic [6:0]       ld_pat = '0;
  logic [2:0]       ld_layer = '0;
  logic [WW-1:0]    ld_word = '0;
  logic             road_rdy = 1'b0;
  logic             road_vld;
  logic [6:0]       road_id;
  logic             road_eoe;

  always #2.5 clk = ~clk;

  road_matcher dut (
    .clk(clk), .rst_n(rst_n), .hit_vld(hit_vld), .hit_word(hit_word),
    .eoe(eoe), .cfg_thr(cfg_thr), .ld_en(ld_en), .ld_pat(ld_pat),
    .ld_layer(ld_layer), .ld_word(ld_word), .road_rdy(road_rdy),
    .road_vld(road_vld), .road_id(road_id), .road_eoe(road_eoe)
  );

  // Behavioural reference
  int    m_pat [NP][NL];
  bit    m_flg [NP][NL];
  bit    m_srv [NP];
  int    m_st;    // 0 idle, 1 collecting, 2 reading out
  int    m_thr;
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 0;
  string cur_req = "R1";

  function automatic int m_first();
    for (int p = 0; p < NP; p++) begin
      int c = 0;
      for (int l = 0; l < NL; l++) c += m_flg[p][l];
      if (!m_srv[p] && c >= m_thr) return p;
    end
    return -1;
  endfunction

  function automatic logic [WW-1:0] wgen(input int p, input int l);
    return WW'(12'h800 | (p << 3) | l);
  endfunction

  task automatic m_reset();
    for (int p = 0; p < NP; p++) begin
      m_srv[p] = 0;
      for (int l = 0; l < NL; l++) begin m_pat[p][l] = 0; m_flg[p][l] = 0; end
    end
    m_st = 0; m_thr = 6;
  endtask

  task automatic m_step();
    int st0 = m_st;
    int f = m_first();
    if (st0 != 2)
      for (int l = 0; l < NL; l++)
        if (hit_vld[l])
          for (int p = 0; p < NP; p++)
            if (m_pat[p][l] == int'(hit_word[l*WW +: WW])) m_flg[p][l] = 1;
    if (ld_en && st0 == 0 && hit_vld == 0 && !eoe && ld_layer < NL)
      m_pat[ld_pat][ld_layer] = int'(ld_word);
    if (st0 != 2) begin
      if (eoe) begin
        m_thr = (cfg_thr == 0) ? 1 : (cfg_thr > NL) ? NL : int'(cfg_thr);
        m_st = 2;
        for (int p = 0; p < NP; p++) m_srv[p] = 0;
      end else if (st0 == 0 && hit_vld != 0) m_st = 1;
    end else if (road_rdy) begin
      if (f >= 0) m_srv[f] = 1;
      else begin
        for (int p = 0; p < NP; p++) for (int l = 0; l < NL; l++) m_flg[p][l] = 0;
        m_st = 0;
      end
    end
  endtask

  task automatic compare();
    int f = m_first();
    bit ev = (m_st == 2);
    bit ee = ev && (f < 0);
    int ei = (ev && f >= 0) ? f : 0;
    n_vec++;
    if (road_vld !== ev || road_eoe !== ee || int'(road_id) != ei || $isunknown(road_id)) begin
      n_bad++;
      $display("FAIL %s: vld/eoe/id act=%0b/%0b/%0d exp=%0b/%0b/%0d",
               cur_req, road_vld, road_eoe, road_id, ev, ee, ei);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    m_step();
    #1;
    compare();
  endtask

  task automatic clr_in();
    hit_vld = '0; hit_word = '0; eoe = 0; ld_en = 0;
  endtask

  task automatic load(input int p, input int l, input logic [WW-1:0] w);
    ld_en = 1; ld_pat = 7'(p); ld_layer = 3'(l); ld_word = w;
    tick();
    ld_en = 0;
  endtask

  task automatic put(input int l, input logic [WW-1:0] w);
    hit_vld[l] = 1'b1;
    hit_word[l*WW +: WW] = w;
  endtask

  task automatic full_pat(input int p, input int nlay);
    for (int l = 0; l < nlay; l++) begin put(l, wgen(p, l)); tick(); clr_in(); end
  endtask

  task automatic end_evt(input int t);
    cfg_thr = 3'(t); eoe = 1;
    tick();
    eoe = 0;
  endtask

  task automatic drain(input int mode);
    for (int i = 0; i < 600 && m_st == 2; i++) begin
      road_rdy = (mode == 0) ? 1'b1 : 1'(i % 3 == 2);
      tick();
    end
    road_rdy = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: act=running exp=finished");
    finish_run();
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: idle after reset
    cur_req = "R1";
    tick(); tick();

    // R2: load patterns 0..15
    cur_req = "R2";
    for (int p = 0; p < 16; p++) for (int l = 0; l < NL; l++) load(p, l, wgen(p, l));
    load(15, 6, 12'h0AB);   // layer index out of range

    // R3 / R5: all six buses at once for pattern 3, five layers of pattern 7
    cur_req = "R3";
    for (int l = 0; l < NL; l++) put(l, wgen(3, l));
    tick(); clr_in();
    full_pat(7, 5);
    cur_req = "R5";
    end_evt(6);
    cur_req = "R7";
    drain(0);

    // R4: repeats and a cross-layer word
    cur_req = "R4";
    put(0, wgen(5, 0)); tick(); clr_in();
    put(0, wgen(5, 0)); put(1, wgen(5, 1)); put(2, wgen(5, 3)); tick(); clr_in();
    put(0, wgen(6, 0)); put(1, wgen(6, 1)); tick(); clr_in();
    put(2, wgen(6, 2)); put(2, wgen(6, 2)); tick(); clr_in();
    put(2, wgen(6, 2)); tick(); clr_in();
    end_evt(3);
    drain(0);

    // R5: clamp 0 -> 1 and 7 -> 6; hits on the eoe cycle count (R3)
    cur_req = "R5";
    put(2, wgen(9, 2));
    end_evt(0); clr_in();
    drain(0);
    full_pat(10, 6);
    full_pat(11, 5);
    end_evt(7);
    drain(0);

    // R6: several roads, sent in reverse order, readout with stalls
    cur_req = "R6";
    full_pat(14, 6); full_pat(8, 6); full_pat(2, 6); full_pat(1, 6);
    end_evt(6);
    drain(1);

    // R8: hits, eoe and loads during readout are ignored
    cur_req = "R8";
    full_pat(4, 6);
    end_evt(6);
    for (int l = 0; l < NL; l++) put(l, wgen(12, l));
    cfg_thr = 3'd1; eoe = 1;
    tick(); tick(); clr_in();
    ld_en = 1; ld_pat = 7'd4; ld_layer = 3'd0; ld_word = 12'h123;
    tick(); ld_en = 0;
    drain(1);
    full_pat(4, 6);   // pattern 4 must still be intact
    end_evt(6);
    drain(0);

    // R9: empty event
    cur_req = "R9";
    end_evt(6);
    drain(0);

    // R2: load during an open event is dropped
    cur_req = "R2";
    put(0, wgen(13, 0)); tick(); clr_in();
    load(20, 0, 12'h055);
    end_evt(6);
    load(21, 0, 12'h056);
    drain(0);
    put(0, 12'h055); tick(); clr_in();
    put(0, 12'h056); tick(); clr_in();
    end_evt(1);
    drain(0);

    // Mixed random traffic against the reference
    cur_req = "R3";
    for (int i = 0; i < 4000; i++) begin
      for (int l = 0; l < NL; l++) begin
        int p = int'($urandom % 20);
        hit_vld[l] = 1'($urandom % 3 == 0);
        hit_word[l*WW +: WW] = ($urandom % 5 == 0) ? wgen(p, (l + 1) % NL) : wgen(p, l);
      end
      eoe      = 1'($urandom % 40 == 0);
      cfg_thr  = 3'($urandom % 8);
      road_rdy = 1'($urandom % 2);
      ld_en    = 1'($urandom % 16 == 0);
      ld_pat   = 7'($urandom % 32);
      ld_layer = 3'($urandom % 8);
      ld_word  = wgen(int'($urandom % 20), int'($urandom % NL));
      tick();
    end
    clr_in();
    cur_req = "R6";
    drain(0);
    tick();
    finish_run();
  end

endmodule